// File: doc/BRIEF.md
# Hook-State Access Watchdog

This block keeps the two bits that decide whether a telephone line interface is off-hook: a direct off-hook bit, and a pin-enable bit that hands control to an external off-hook pin. It also watches host register activity. After software turns the watchdog on, the block expects to see a register write at least once per window, four seconds by default. If the host writes nothing for a full window, the block clears both hook bits, and the line falls back on-hook. The rest of the system is not reset.

Every register write starts the window again. This includes a plain register write strobe and any write to the enable bit or to either hook bit. The enable bit is sticky. Writing a one sets it, and after that only the hardware reset clears it. The external pin passes through a two-stage synchronizer before it is combined with the bits. After a timeout, the line goes off-hook again only when software sets one of the hook bits.

Top module: `hook_watchdog`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, offhook, timeout, wd_on, oh_bit and ohe_bit are all 0.
- R2: A cycle with en_wr=1 and en_din=1 sets wd_on at the next clock edge. A write with en_din=0 leaves wd_on as it was. Only rst_n low clears wd_on.
- R3: oh_wr=1 loads oh_din into oh_bit at the next clock edge, and ohe_wr=1 loads ohe_din into ohe_bit, unless a timeout fires on that same edge.
- R4: offhook is 1 when oh_bit is 1, or when ohe_bit is 1 and the value of hook_pin from two clock edges earlier is 1.
- R5: While wd_on is 0, timeout stays 0 and the hook bits are never cleared, however long the host stays idle.
- R6: While wd_on is 1, if the last write was sampled at clock edge E, timeout is 1 for the single cycle after edge E+TICKS, where TICKS = CLK_HZ*WINDOW_S. At that same edge oh_bit and ohe_bit both become 0.
- R7: Any cycle with reg_wr, en_wr, oh_wr or ohe_wr high restarts the window, and no timeout fires at that edge.
- R8: After a timeout, the counter stays idle, and no further timeout pulse occurs until the next write.
- R9: After a timeout, setting oh_bit, or setting ohe_bit while hook_pin is high, brings offhook back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| reg_wr | input | 1 | Strobe for any other register write |
| en_wr | input | 1 | Write strobe for the watchdog enable bit |
| en_din | input | 1 | Value written to the enable bit |
| oh_wr | input | 1 | Write strobe for the off-hook bit |
| oh_din | input | 1 | Value written to the off-hook bit |
| ohe_wr | input | 1 | Write strobe for the pin-enable bit |
| ohe_din | input | 1 | Value written to the pin-enable bit |
| hook_pin | input | 1 | External off-hook request, asynchronous |
| offhook | output | 1 | Effective off-hook state |
| timeout | output | 1 | One-cycle pulse when the window expires |
| wd_on | output | 1 | Current value of the watchdog enable bit |
| oh_bit | output | 1 | Current value of the off-hook bit |
| ohe_bit | output | 1 | Current value of the pin-enable bit |

## Verification
A fault in the window counter shows up as a timeout pulse that comes one or more cycles too early or too late after the last write. The hook bits are cleared on that same wrong edge, so the fault appears at the ports within about one window. An armed flag stuck high produces repeated pulses one window apart after the first timeout. A stuck enable or synchronizer fault shows on wd_on or offhook within two cycles of the write or pin edge that exposes it. The bench drives the block with random, sparse writes so that many full windows expire, and it compares every output on every cycle.

// File: rtl/hook_watchdog.sv
module hook_watchdog #(
  parameter longint CLK_HZ   = 100_000_000,
  parameter int     WINDOW_S = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr,
  input  logic en_wr,
  input  logic en_din,
  input  logic oh_wr,
  input  logic oh_din,
  input  logic ohe_wr,
  input  logic ohe_din,
  input  logic hook_pin,
  output logic offhook,
  output logic timeout,
  output logic wd_on,
  output logic oh_bit,
  output logic ohe_bit
);
  localparam longint TICKS = CLK_HZ * WINDOW_S;
  localparam int     CW    = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;
  logic          armed;
  logic [1:0]    pin_sync;
  logic          restart;
  logic          expire;

  assign restart = reg_wr | en_wr | oh_wr | ohe_wr;
  assign expire  = wd_on & armed & ~restart & (cnt == LAST);
  assign offhook = oh_bit | (ohe_bit & pin_sync[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[0], hook_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wd_on <= 1'b0;
    else if (en_wr && en_din)  wd_on <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (expire) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (wd_on && armed) begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oh_bit  <= 1'b0;
      ohe_bit <= 1'b0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire;
      if (expire) begin
        oh_bit  <= 1'b0;
        ohe_bit <= 1'b0;
      end else begin
        if (oh_wr)  oh_bit  <= oh_din;
        if (ohe_wr) ohe_bit <= ohe_din;
      end
    end
  end
endmodule

module hook_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic en_wr,
  input logic oh_wr,
  input logic oh_din,
  input logic timeout,
  input logic wd_on,
  input logic oh_bit,
  input logic ohe_bit
);
  logic any_wr;
  assign any_wr = reg_wr | en_wr | oh_wr;

  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_on |=> wd_on);
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_on |-> !timeout);
  a_r6_bits_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!oh_bit && !ohe_bit));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  a_r7_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> !timeout);
  a_r3_oh_load: assert property (@(posedge clk) disable iff (!rst_n)
    oh_wr |=> (oh_bit == $past(oh_din)));
endmodule

bind hook_watchdog hook_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .en_wr(en_wr), .oh_wr(oh_wr),
  .oh_din(oh_din), .timeout(timeout), .wd_on(wd_on), .oh_bit(oh_bit),
  .ohe_bit(ohe_bit)
);

// File: tb/hook_watchdog_test.sv
`timescale 1ns/1ps
module hook_watchdog_test;
  localparam longint HZ = 5;
  localparam int     WS = 4;
  localparam int     T  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, en_wr = 0, en_din = 0, oh_wr = 0, oh_din = 0;
  logic ohe_wr = 0, ohe_din = 0, hook_pin = 0;
  logic offhook, timeout, wd_on, oh_bit, ohe_bit;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  bit m_en, m_oh, m_ohe, m_tmo, m_armed, s1, s2;
  int m_cnt;

  always #2.5 clk = ~clk;

  hook_watchdog #(.CLK_HZ(HZ), .WINDOW_S(WS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .en_wr(en_wr), .en_din(en_din),
    .oh_wr(oh_wr), .oh_din(oh_din), .ohe_wr(ohe_wr), .ohe_din(ohe_din),
    .hook_pin(hook_pin), .offhook(offhook), .timeout(timeout), .wd_on(wd_on),
    .oh_bit(oh_bit), .ohe_bit(ohe_bit));

  function automatic bit exp_offhook();
    return m_oh | (m_ohe & s2);
  endfunction

  task automatic model_reset();
    m_en = 0; m_oh = 0; m_ohe = 0; m_tmo = 0; m_armed = 0; s1 = 0; s2 = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    bit wr, fire;
    wr   = reg_wr | en_wr | oh_wr | ohe_wr;
    fire = m_en && m_armed && !wr && (m_cnt == T - 1);
    s2 = s1; s1 = hook_pin;
    m_tmo = fire;
    if (fire) begin m_oh = 0; m_ohe = 0; end
    else begin
      if (oh_wr)  m_oh  = oh_din;
      if (ohe_wr) m_ohe = ohe_din;
    end
    if (wr) begin m_cnt = 0; m_armed = 1; end
    else if (fire) begin m_cnt = 0; m_armed = 0; end
    else if (m_en && m_armed) m_cnt++;
    if (en_wr && en_din) m_en = 1;
  endtask

  task automatic chk(string r, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag, "wd_on",   wd_on,   m_en);
    chk(tag, "oh_bit",  oh_bit,  m_oh);
    chk(tag, "ohe_bit", ohe_bit, m_ohe);
    chk(tag, "offhook", offhook, exp_offhook());
    chk(tag, "timeout", timeout, m_tmo);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    reg_wr = 0; en_wr = 0; oh_wr = 0; ohe_wr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  int pulses;

  initial begin
    model_reset();
    repeat (3) begin
      @(negedge clk);
      tag = "R1";
      check_all();
    end
    rst_n = 1;
    cyc();

    tag = "R5";
    oh_wr = 1; oh_din = 1; ohe_wr = 1; ohe_din = 1; cyc();
    idle(3 * T);
    chk("R5", "oh kept", oh_bit, 1'b1);

    tag = "R2";
    en_wr = 1; en_din = 0; cyc();
    idle(T + 3);
    chk("R2", "zero write ignored", wd_on, 1'b0);
    en_wr = 1; en_din = 1; cyc();
    chk("R2", "enable set", wd_on, 1'b1);

    tag = "R7";
    for (int k = 0; k < 4; k++) begin
      idle(T - 1);
      case (k)
        0: reg_wr = 1;
        1: begin oh_wr = 1; oh_din = 1; end
        2: begin ohe_wr = 1; ohe_din = 1; end
        default: begin en_wr = 1; en_din = 0; end
      endcase
      cyc();
    end
    chk("R7", "no timeout yet", oh_bit, 1'b1);

    tag = "R6";
    idle(T - 1);
    chk("R6", "one before expiry", timeout, 1'b0);
    cyc();
    chk("R6", "pulse at window", timeout, 1'b1);
    chk("R6", "oh cleared", oh_bit, 1'b0);

    tag = "R8";
    pulses = 0;
    for (int i = 0; i < 3 * T; i++) begin cyc(); pulses += timeout; end
    chk("R8", "no repeat pulse", pulses != 0, 1'b0);

    tag = "R2";
    en_wr = 1; en_din = 0; cyc();
    chk("R2", "still enabled", wd_on, 1'b1);

    tag = "R9";
    hook_pin = 1; ohe_wr = 1; ohe_din = 1; cyc();
    idle(2);
    chk("R9", "pin path offhook", offhook, 1'b1);
    hook_pin = 0; idle(2);
    oh_wr = 1; oh_din = 1; cyc();
    chk("R9", "bit offhook", offhook, 1'b1);

    tag = "R4";
    hook_pin = 1; cyc();
    chk("R4", "sync stage 1", offhook, 1'b1);

    tag = "R3,R4,R6";
    process_seed();
    for (int i = 0; i < 6000; i++) begin
      reg_wr  = ($urandom_range(0, 59) == 0);
      en_wr   = ($urandom_range(0, 299) == 0);
      en_din  = $urandom_range(0, 1);
      oh_wr   = ($urandom_range(0, 69) == 0);
      oh_din  = $urandom_range(0, 1);
      ohe_wr  = ($urandom_range(0, 69) == 0);
      ohe_din = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) hook_pin = ~hook_pin;
      cyc();
    end

    tag = "R1";
    rst_n = 0; model_reset();
    #1;
    check_all();
    @(negedge clk); rst_n = 1;
    cyc();

    done = 1;
  end

  task automatic process_seed();
    int unsigned s;
    s = $urandom(32'h5EED_2024);
    if (s == 0) checks = checks;
  endtask

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule